// File: doc/BRIEF.md
# Cartridge ROM Bank Paging Mapper

This block sits between an 8-bit processor bus and a 512 KB static RAM that holds thirty-two 16 KB ROM images, one per slot. It watches processor memory reads, decides whether each one falls in the lower ROM window or the upper ROM window, and turns it into a 19-bit SRAM address with chip enable and output enable. The SRAM is used purely as ROM, so write cycles never reach it.

Two small registers steer the mapping. The upper select register takes a logical ROM number from an I/O write. Numbers 0x80 to 0x9F name a slot directly. A compatibility switch also lets the two legacy numbers 0 and 7 reach slots 1 and 2. The lower configuration register picks which of the first eight slots acts as the lower ROM and which 16 KB quarter of the lower 48 KB it appears in. Slot choice for a read is purely combinational from the address bits and the two registers, so a read that alternates between lower and upper ROM needs no wait state.

Top module: `rom_bank_mapper`

## Requirements
- R1: When the SRAM is enabled (sram_ce_n low), sram_addr is the 5-bit slot number followed by cpu_addr[13:0], so slot n occupies bytes n*0x4000 to n*0x4000+0x3FFF.
- R2: An I/O write (io_wr high at a rising clock edge) with cpu_addr[13] low loads cpu_data into the upper select register; with cpu_addr[13] high the upper select register keeps its value.
- R3: An upper select value from 0x80 to 0x9F maps an upper read to the slot given by its low 5 bits.
- R4: With compat_en high, upper select value 0x00 maps to slot 1 and 0x07 to slot 2; with compat_en low those values map to no slot.
- R5: Any other upper select value maps to no slot, and an upper read then leaves sram_ce_n and sram_oe_n high.
- R6: The lower ROM is unaffected by the upper select register; after reset, with lower_en high, reads in 0x0000-0x3FFF come from slot 0 with no register write.
- R7: A write with lower_cfg_we high at a rising edge loads the lower configuration: cpu_data[2:0] is the lower slot (0-7) and cpu_data[4:3] the window: 01 selects 0x4000-0x7FFF, 10 selects 0x8000-0xBFFF, 00 and 11 select 0x0000-0x3FFF.
- R8: Upper reads occupy 0xC000-0xFFFF and are mapped in the same cycle as the address, with no registers on the path from cpu_addr to the SRAM outputs.
- R9: When mem_wr is high, sram_ce_n and sram_oe_n stay high whatever the address or enables.
- R10: A read with neither enable high, or with an address outside every enabled window, leaves sram_ce_n and sram_oe_n high; sram_oe_n is low exactly when sram_ce_n is low.
- R11: Reset (rst_n low) sets the upper select register to 0x80, the lower slot to 0 and the lower window to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the two configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor write data, used by I/O writes |
| mem_rd | input | 1 | Memory read cycle strobe, active high |
| mem_wr | input | 1 | Memory write cycle strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| lower_cfg_we | input | 1 | Decoded write strobe for the lower configuration register |
| lower_en | input | 1 | Lower ROM enabled |
| upper_en | input | 1 | Upper ROM enabled |
| compat_en | input | 1 | Enables the legacy ROM 0 and ROM 7 aliases |
| sram_addr | output | 19 | SRAM byte address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The hardest case to reach is a relocated lower ROM combined with an upper select holding an alias or an unmapped number, while reads hop between every quarter of the address space with both enables and the alias switch changing. Getting there needs a configuration write followed by reads, so the stimulus interleaves random configuration writes (upper select values weighted toward the direct range, the two alias numbers and a few unmapped values; lower configuration bytes over all eight slots and all four window codes) between random read and write vectors, after directed cases for reset, the ignored port write and each window code.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   // 16 KB quarter of the processor address space, from cpu_addr[15:14]
   typedef enum logic [1:0] {
      QTR_0000 = 2'b00,
      QTR_4000 = 2'b01,
      QTR_8000 = 2'b10,
      QTR_C000 = 2'b11
   } quarter_t;

   // Lower window code -> quarter; code 11 falls back to the bottom quarter
   function automatic quarter_t win_code_to_qtr(input logic [1:0] code);
      case (code)
         2'b01:   return QTR_4000;
         2'b10:   return QTR_8000;
         default: return QTR_0000;
      endcase
   endfunction
endpackage

// File: rtl/rbm_cfg_regs.sv
module rbm_cfg_regs #(
   parameter int DATA_W     = 8,
   parameter int PAGE_W     = 3,
   parameter int SEL_RESET  = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] upper_sel,
   output logic [PAGE_W-1:0] lower_page,
   output rbm_pkg::quarter_t lower_qtr
);
   localparam int WIN_LSB = PAGE_W;

   initial begin
      if (PAGE_W + 2 > DATA_W)
         $error("lower configuration fields do not fit the data bus");
   end

   logic [1:0] win_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_sel  <= DATA_W'(SEL_RESET);
         lower_page <= '0;
         win_code   <= 2'b00;
      end else begin
         if (sel_we)
            upper_sel <= wdata;
         if (cfg_we) begin
            lower_page <= wdata[PAGE_W-1:0];
            win_code   <= wdata[WIN_LSB+1:WIN_LSB];
         end
      end
   end

   assign lower_qtr = rbm_pkg::win_code_to_qtr(win_code);

   generate
      if (PAGE_W + 2 < DATA_W) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^wdata[DATA_W-1:PAGE_W+2];
      end
   endgenerate
endmodule

// File: rtl/rbm_upper_xlate.sv
module rbm_upper_xlate #(
   parameter int DATA_W     = 8,
   parameter int SLOT_W     = 5,
   parameter bit HAS_COMPAT = 1'b1,
   parameter int DIRECT_TAG = 3'b100,
   parameter int ALIAS_A    = 0,
   parameter int ALIAS_A_TO = 1,
   parameter int ALIAS_B    = 7,
   parameter int ALIAS_B_TO = 2
) (
   input  logic [DATA_W-1:0] rom_num,
   input  logic              compat_en,
   output logic              valid,
   output logic [SLOT_W-1:0] slot
);
   localparam int TAG_W = DATA_W - SLOT_W;

   initial begin
      if (TAG_W < 1)
         $error("slot field must be narrower than the ROM number");
   end

   logic direct_hit;
   assign direct_hit = (rom_num[DATA_W-1:SLOT_W] == TAG_W'(DIRECT_TAG));

   generate
      if (HAS_COMPAT) begin : g_compat
         logic hit_a, hit_b;
         assign hit_a = compat_en && (rom_num == DATA_W'(ALIAS_A));
         assign hit_b = compat_en && (rom_num == DATA_W'(ALIAS_B));
         always_comb begin
            valid = direct_hit || hit_a || hit_b;
            if (direct_hit)  slot = rom_num[SLOT_W-1:0];
            else if (hit_a)  slot = SLOT_W'(ALIAS_A_TO);
            else if (hit_b)  slot = SLOT_W'(ALIAS_B_TO);
            else             slot = '0;
         end
      end else begin : g_plain
         logic unused_compat;
         assign unused_compat = compat_en;
         assign valid = direct_hit;
         assign slot  = rom_num[SLOT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rbm_window_dec.sv
module rbm_window_dec (
   input  logic [1:0]        addr_qtr,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              lower_en,
   input  logic              upper_en,
   input  rbm_pkg::quarter_t lower_qtr,
   input  logic              upper_valid,
   output logic              lower_hit,
   output logic              upper_hit
);
   logic rd_ok;
   assign rd_ok     = mem_rd && !mem_wr;
   assign lower_hit = rd_ok && lower_en && (addr_qtr == lower_qtr);
   assign upper_hit = rd_ok && upper_en && upper_valid &&
                      (addr_qtr == rbm_pkg::QTR_C000);
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper #(
   parameter int CPU_AW       = 16,
   parameter int DATA_W       = 8,
   parameter int NUM_SLOTS    = 32,
   parameter int SLOT_BYTES   = 16384,
   parameter int LOWER_PAGES  = 8,
   parameter int SEL_ADDR_BIT = 13,
   parameter bit HAS_COMPAT   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           cpu_addr,
   input  logic [7:0]            cpu_data,
   input  logic                  mem_rd,
   input  logic                  mem_wr,
   input  logic                  io_wr,
   input  logic                  lower_cfg_we,
   input  logic                  lower_en,
   input  logic                  upper_en,
   input  logic                  compat_en,
   output logic [18:0]           sram_addr,
   output logic                  sram_ce_n,
   output logic                  sram_oe_n
);
   localparam int SLOT_W = $clog2(NUM_SLOTS);
   localparam int OFS_W  = $clog2(SLOT_BYTES);
   localparam int PAGE_W = $clog2(LOWER_PAGES);
   localparam int MEM_AW = SLOT_W + OFS_W;

   initial begin
      if ((1 << SLOT_W) != NUM_SLOTS)  $error("NUM_SLOTS must be a power of two");
      if (OFS_W != CPU_AW - 2)         $error("a slot must span one address quarter");
      if (LOWER_PAGES > NUM_SLOTS)     $error("lower pages exceed slot count");
      if (MEM_AW != 19 || CPU_AW != 16 || DATA_W != 8)
         $error("port widths are fixed at 16/8/19");
      if (SEL_ADDR_BIT >= CPU_AW)      $error("select decode bit out of range");
   end

   logic [DATA_W-1:0] upper_sel;
   logic [PAGE_W-1:0] lower_page;
   rbm_pkg::quarter_t lower_qtr;
   logic              upper_valid;
   logic [SLOT_W-1:0] upper_slot;
   logic              lower_hit, upper_hit;
   logic [SLOT_W-1:0] slot;

   rbm_cfg_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .SEL_RESET(8'h80)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_we     (io_wr && !cpu_addr[SEL_ADDR_BIT]),
      .cfg_we     (lower_cfg_we),
      .wdata      (cpu_data),
      .upper_sel  (upper_sel),
      .lower_page (lower_page),
      .lower_qtr  (lower_qtr)
   );

   rbm_upper_xlate #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .HAS_COMPAT(HAS_COMPAT)) u_xlate (
      .rom_num   (upper_sel),
      .compat_en (compat_en),
      .valid     (upper_valid),
      .slot      (upper_slot)
   );

   rbm_window_dec u_win (
      .addr_qtr    (cpu_addr[CPU_AW-1:CPU_AW-2]),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .lower_en    (lower_en),
      .upper_en    (upper_en),
      .lower_qtr   (lower_qtr),
      .upper_valid (upper_valid),
      .lower_hit   (lower_hit),
      .upper_hit   (upper_hit)
   );

   // Lower window never reaches the top quarter, so the two hits are exclusive
   always_comb begin
      if (lower_hit) slot = SLOT_W'(lower_page);
      else           slot = upper_slot;
   end

   assign sram_addr = {slot, cpu_addr[OFS_W-1:0]};
   assign sram_ce_n = !(lower_hit || upper_hit);
   assign sram_oe_n = sram_ce_n;
endmodule

// File: rtl/rom_bank_mapper_chk.sv
module rom_bank_mapper_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cpu_addr,
   input logic [7:0]  cpu_data,
   input logic        mem_rd,
   input logic        mem_wr,
   input logic        io_wr,
   input logic        lower_cfg_we,
   input logic        lower_en,
   input logic        upper_en,
   input logic [18:0] sram_addr,
   input logic        sram_ce_n,
   input logic        sram_oe_n
);
   AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (sram_ce_n && sram_oe_n)); // R9

   AST_NO_ENABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!lower_en && !upper_en) |-> sram_ce_n); // R10

   AST_CE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_ce_n |-> (mem_rd && sram_oe_n == sram_ce_n)); // R10

   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_ce_n |-> (sram_addr[13:0] == cpu_addr[13:0])); // R1

   AST_UPPER_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (!lower_en && cpu_addr[15:14] != 2'b11) |-> sram_ce_n); // R8

   AST_DIRECT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !cpu_addr[13] && cpu_data[7:5] == 3'b100 && !lower_cfg_we) |=>
      ((mem_rd && !mem_wr && upper_en && cpu_addr[15:14] == 2'b11) |->
       (!sram_ce_n && sram_addr[18:14] == $past(cpu_data[4:0])))); // R3
endmodule

bind rom_bank_mapper rom_bank_mapper_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_addr     (cpu_addr),
   .cpu_data     (cpu_data),
   .mem_rd       (mem_rd),
   .mem_wr       (mem_wr),
   .io_wr        (io_wr),
   .lower_cfg_we (lower_cfg_we),
   .lower_en     (lower_en),
   .upper_en     (upper_en),
   .sram_addr    (sram_addr),
   .sram_ce_n    (sram_ce_n),
   .sram_oe_n    (sram_oe_n)
);

// File: tb/rom_bank_mapper_test.sv
module rom_bank_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        mem_rd = 1'b0, mem_wr = 1'b0, io_wr = 1'b0, lower_cfg_we = 1'b0;
   logic        lower_en = 1'b0, upper_en = 1'b0, compat_en = 1'b0;
   logic [18:0] sram_addr;
   logic        sram_ce_n, sram_oe_n;

   int checks = 0, fails = 0;
   logic [7:0] m_sel = 8'h80;
   logic [7:0] m_cfg = 8'h00;

   always #4 clk = ~clk;

   rom_bank_mapper uut (.*);

   // model: {hit, slot}
   function automatic logic [5:0] exp_map(input logic [15:0] a, input logic rd, wr,
                                          le, ue, ce, input logic [7:0] us, lc);
      logic [1:0] win;
      logic       uv;
      logic [4:0] us_slot;
      case (lc[4:3]) 2'b01: win = 2'b01; 2'b10: win = 2'b10; default: win = 2'b00; endcase
      uv = 1'b1; us_slot = us[4:0];
      if (us[7:5] == 3'b100)        us_slot = us[4:0];
      else if (ce && us == 8'h00)   us_slot = 5'd1;
      else if (ce && us == 8'h07)   us_slot = 5'd2;
      else                          uv = 1'b0;
      if (!rd || wr)                      return 6'd0;
      if (le && a[15:14] == win)          return {1'b1, 2'b00, lc[2:0]};
      if (ue && uv && a[15:14] == 2'b11)  return {1'b1, us_slot};
      return 6'd0;
   endfunction

   task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic cfg);
      @(negedge clk);
      cpu_addr = a; cpu_data = d; mem_rd = 0; mem_wr = 0;
      io_wr = !cfg; lower_cfg_we = cfg;
      @(negedge clk);
      io_wr = 0; lower_cfg_we = 0;
      if (cfg) m_cfg = d;
      else if (!a[13]) m_sel = d;
   endtask

   task automatic apply(input string tag, input logic [15:0] a, input logic rd, wr,
                        le, ue, ce);
      logic [5:0] e;
      @(negedge clk);
      cpu_addr = a; mem_rd = rd; mem_wr = wr; lower_en = le; upper_en = ue; compat_en = ce;
      #1;
      e = exp_map(a, rd, wr, le, ue, ce, m_sel, m_cfg);
      checks++;
      if (sram_ce_n != !e[5] || sram_oe_n != !e[5] ||
          (e[5] && sram_addr != {e[4:0], a[13:0]})) begin
         fails++;
         $display("FAIL %s addr=%h: got ce_n=%b oe_n=%b sram_addr=%h, expected ce_n=%b sram_addr=%h",
                  tag, a, sram_ce_n, sram_oe_n, sram_addr, !e[5], {e[4:0], a[13:0]});
      end
   endtask

   initial begin : watchdog
      #1600000;
      fails++;
      $display("FAIL watchdog expired: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] pick;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 / R6: reset state
      apply("R11 lower slot0", 16'h0123, 1, 0, 1, 0, 0);
      apply("R6 lower default", 16'h3FFF, 1, 0, 1, 1, 0);
      apply("R11 upper 0x80", 16'hC456, 1, 0, 0, 1, 0);
      apply("R10 no enable", 16'hC456, 1, 0, 0, 0, 0);
      // R3 direct selection incl. top slot
      io_write(16'h1F00, 8'h9F, 0);
      apply("R3 slot31", 16'hFFFF, 1, 0, 1, 1, 0);
      // R2 ignored write with bit13 high
      io_write(16'h2F00, 8'h85, 0);
      apply("R2 ignored port", 16'hC000, 1, 0, 0, 1, 0);
      // R6 upper select does not touch lower
      apply("R6 lower unaffected", 16'h0010, 1, 0, 1, 1, 0);
      // R4 aliases
      io_write(16'h0000, 8'h00, 0);
      apply("R4 alias0 on", 16'hC111, 1, 0, 0, 1, 1);
      apply("R4 alias0 off", 16'hC111, 1, 0, 0, 1, 0);
      io_write(16'h0000, 8'h07, 0);
      apply("R4 alias7 on", 16'hD222, 1, 0, 0, 1, 1);
      // R5 unmapped number
      io_write(16'h0000, 8'h05, 0);
      apply("R5 unmapped", 16'hE000, 1, 0, 0, 1, 1);
      // R7 window codes
      io_write(16'h0000, {3'b0, 2'b01, 3'd5}, 1);
      apply("R7 win4000 hit", 16'h4567, 1, 0, 1, 0, 0);
      apply("R7 win4000 old gone", 16'h0567, 1, 0, 1, 0, 0);
      io_write(16'h0000, {3'b111, 2'b10, 3'd7}, 1);
      apply("R7 win8000", 16'hBFFF, 1, 0, 1, 0, 0);
      io_write(16'h0000, {3'b0, 2'b11, 3'd3}, 1);
      apply("R7 code11 bottom", 16'h0001, 1, 0, 1, 0, 0);
      // R8 both enabled, alternating windows
      io_write(16'h0000, 8'h8A, 0);
      apply("R8 upper same cycle", 16'hCAFE, 1, 0, 1, 1, 0);
      apply("R8 lower same cycle", 16'h0ACE, 1, 0, 1, 1, 0);
      // R9 writes blocked
      apply("R9 write upper", 16'hCAFE, 0, 1, 1, 1, 1);
      apply("R9 write lower", 16'h0ACE, 1, 1, 1, 1, 1);
      // R1 random mix
      for (int i = 0; i < 3000; i++) begin
         pick = 8'($urandom_range(0, 15));
         if (pick == 0) begin
            case ($urandom_range(0, 3))
               0: io_write(16'($urandom), 8'h80 | 8'($urandom_range(0, 31)), 0);
               1: io_write(16'($urandom) & 16'hDFFF, ($urandom_range(0, 1) != 0) ? 8'h07 : 8'h00, 0);
               2: io_write(16'($urandom), 8'($urandom), 0);
               default: io_write(16'($urandom), 8'($urandom), 1);
            endcase
         end else begin
            logic [15:0] a;
            logic rd, wr, le, ue, ce;
            a = 16'($urandom); rd = ($urandom_range(0, 7) != 0); wr = ($urandom_range(0, 7) == 0);
            le = 1'($urandom); ue = 1'($urandom); ce = 1'($urandom);
            apply(wr ? "R9 random" : (a[15:14] == 2'b11 ? "R3 random upper" : "R1 random lower"),
                  a, rd, wr, le, ue, ce);
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule